// File: doc/BRIEF.md
# Probe-Serviced Debug Memory Bridge

This block sits on the load/store/fetch path of a core and catches every access that a core in debug mode makes into a reserved high window of the virtual address space. It does not send such an access to system memory. It stalls the core and publishes the access in three registers that the test port can read and write: a control word, an address word and a data word. An external probe polls the control word and sees a pending flag. It reads the address, direction and size of the access, then moves data through the data word. For a store the probe reads the data word; for a load or fetch it writes the data word. The probe then writes the control word to mark the access done, and that releases the core. Accesses outside the window pass straight through to a system memory port.

The core request port is valid/ready. Once the core raises `core_req_valid`, it must hold the valid signal and every request field stable until `core_req_ready` is sampled high. `core_req_ready` marks completion, and `core_rsp_rdata` and `core_rsp_err` are valid only in that cycle. The bridge never raises ready before an access is complete, so a probe access back-pressures the core for as long as the probe takes. The memory port mirrors the same rule: `mem_req_valid` is offered only while the bridge is idle, and `mem_req_ready` completes it in the same cycle. The test-port side is a plain register select with a write strobe and a combinational read-back. The scan state machine that drives it lies outside this block.

Top module: `prb_access_bridge`

## Requirements
- R1: A request whose top WIN_BITS address bits equal WIN_TAG and that is made with `core_req_debug`=1 never raises `mem_req_valid`. Any request outside the window is offered on the memory port with the same address, size and write flag, and completes (ready, memory read data returned) in the cycle that `mem_req_ready` is high.
- R2: One cycle after a debug-mode window request is accepted, bit 0 (pending) of the control word reads 1.
- R3: While an access is posted, the address word reads the request address with its top WIN_BITS bits cleared.
- R4: The control word reports the direction in bit 1 (1 = store), the fetch flag in bit 2 and the size in bits 4:3 (0 = byte, 1 = halfword, 2 = word).
- R5: For a store, the data word holds the core write data shifted down by 8×(address low bits) and masked to the access size.
- R6: For a load or fetch, the data word starts at zero. The probe writes data right-justified, and the core receives it masked to the access size and shifted up by 8×(address low bits), with all other lanes zero. A store completes with read data zero.
- R7: If the probe writes the control word with bit 0 = 0 while an access is pending, the pending bit clears on the next cycle and `core_req_ready` is high for exactly that one cycle. The same write when nothing is pending has no effect.
- R8: While an access is pending, `core_req_ready` stays low for any number of cycles. Probe writes to the address word, and control writes with bit 0 = 1, change nothing.
- R9: A fetch uses the same probe path as a load. It is reported as a read with the fetch bit set, even if `core_req_write` is high.
- R10: A window request made with `core_req_debug`=0 completes in the same cycle with `core_rsp_err`=1. It raises no memory request and posts nothing to the probe.
- R11: After reset, the control, address and data words read zero and `core_req_ready` is low while no request is offered.
- R12: `tp_sel` selects 0 = control, 1 = address, 2 = data. Selection 3 reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| core_req_valid | input | 1 | Core request offered |
| core_req_ready | output | 1 | Request complete; response valid this cycle |
| core_req_debug | input | 1 | Core is in debug mode |
| core_req_fetch | input | 1 | Request is an instruction fetch |
| core_req_write | input | 1 | Request is a store |
| core_req_size | input | 2 | Access size: 0 byte, 1 halfword, 2 word |
| core_req_addr | input | AW | Virtual address |
| core_req_wdata | input | DW | Store data on its byte lanes |
| core_rsp_rdata | output | DW | Load/fetch data on its byte lanes |
| core_rsp_err | output | 1 | Window access outside debug mode |
| mem_req_valid | output | 1 | Request to system memory |
| mem_req_ready | input | 1 | System memory completes the request |
| mem_req_write | output | 1 | Store to system memory |
| mem_req_size | output | 2 | Size to system memory |
| mem_req_addr | output | AW | Address to system memory |
| mem_req_wdata | output | DW | Store data to system memory |
| mem_rsp_rdata | input | DW | Read data from system memory |
| tp_sel | input | 2 | Probe register select |
| tp_wr | input | 1 | Probe register write strobe |
| tp_wdata | input | DW | Probe write data |
| tp_rdata | output | DW | Selected probe register value |

## Verification
The bench builds the bridge with DW=32, AW=16, WIN_BITS=4 and WIN_TAG=4'hF, so the window is the top sixteenth of a 64 KiB space. With that configuration it can sweep every legal combination of size, byte-lane offset and access kind (load, store, fetch). It also tests both sides of the window edge at 0xEFFC and 0xF000, and requests in and out of debug mode on each side. For every posted access it computes the shifted and masked data words, the cleared address and the control field encodings arithmetically. It also holds each stall for a different number of cycles while trying writes that should be ignored.

// File: rtl/prb_pkg.sv
`timescale 1ns/1ps
package prb_pkg;
  localparam int SZW = 2;

  // control word bit positions (probe-visible encoding)
  localparam int CTL_PEND  = 0;
  localparam int CTL_WR    = 1;
  localparam int CTL_FETCH = 2;
  localparam int CTL_SZ    = 3;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_ADDR = 2'd1,
    SEL_DATA = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_DONE = 2'd2
  } bst_e;

  typedef struct packed {
    logic           wr;
    logic           fetch;
    logic [SZW-1:0] size;
  } acc_attr_t;
endpackage

// File: rtl/prb_win_decode.sv
`timescale 1ns/1ps
module prb_win_decode #(
  parameter int AW = 32,
  parameter int WIN_BITS = 8,
  parameter logic [WIN_BITS-1:0] WIN_TAG = '1
) (
  input  logic [AW-1:0] addr,
  output logic          hit,
  output logic [AW-1:0] phys
);
  localparam int OFFW = AW - WIN_BITS;

  assign hit  = (addr[AW-1 -: WIN_BITS] == WIN_TAG);
  assign phys = {{WIN_BITS{1'b0}}, addr[OFFW-1:0]};
endmodule

// File: rtl/prb_lane_align.sv
`timescale 1ns/1ps
module prb_lane_align
  import prb_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [$clog2(DW/8)-1:0] lane_off,
  input  logic [SZW-1:0]          size,
  input  logic [DW-1:0]           core_wdata,
  input  logic [DW-1:0]           probe_rdata,
  output logic [DW-1:0]           wdata_rj,
  output logic [DW-1:0]           rdata_lane
);
  localparam int LANES = DW / 8;
  localparam int LB    = $clog2(LANES);

  logic [DW-1:0]   keep;
  logic [LB+2:0]   shamt;

  // a right-justified lane survives when its index is below 2**size
  generate
    for (genvar i = 0; i < LANES; i++) begin : g_lane
      assign keep[8*i +: 8] = {8{(32'(i) >> size) == 32'd0}};
    end
  endgenerate

  assign shamt      = {lane_off, 3'b000};
  assign wdata_rj   = (core_wdata >> shamt) & keep;
  assign rdata_lane = (probe_rdata & keep) << shamt;
endmodule

// File: rtl/prb_probe_regs.sv
`timescale 1ns/1ps
module prb_probe_regs
  import prb_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          post,
  input  logic [AW-1:0] post_phys,
  input  acc_attr_t     post_attr,
  input  logic [DW-1:0] post_data,
  input  logic [1:0]    tp_sel,
  input  logic          tp_wr,
  input  logic [DW-1:0] tp_wdata,
  output logic [DW-1:0] tp_rdata,
  output logic          pend,
  output logic          done,
  output logic [DW-1:0] data_word
);
  logic          pend_q;
  acc_attr_t     attr_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;
  logic [DW-1:0] ctrl_word;
  reg_sel_e      sel;
  logic          ctl_wr;
  logic          dat_wr;

  assign sel    = reg_sel_e'(tp_sel);
  assign ctl_wr = tp_wr && (sel == SEL_CTRL);
  assign dat_wr = tp_wr && (sel == SEL_DATA);
  assign done   = pend_q && ctl_wr && !tp_wdata[CTL_PEND];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      attr_q <= '0;
      addr_q <= '0;
      data_q <= '0;
    end else if (post) begin
      pend_q <= 1'b1;
      attr_q <= post_attr;
      addr_q <= post_phys;
      data_q <= post_attr.wr ? post_data : '0;
    end else begin
      if (done)   pend_q <= 1'b0;
      if (dat_wr) data_q <= tp_wdata;
    end
  end

  always_comb begin
    ctrl_word                 = '0;
    ctrl_word[CTL_PEND]       = pend_q;
    ctrl_word[CTL_WR]         = attr_q.wr;
    ctrl_word[CTL_FETCH]      = attr_q.fetch;
    ctrl_word[CTL_SZ +: SZW]  = attr_q.size;
  end

  always_comb begin
    case (sel)
      SEL_CTRL: tp_rdata = ctrl_word;
      SEL_ADDR: tp_rdata = DW'(addr_q);
      SEL_DATA: tp_rdata = data_q;
      default:  tp_rdata = '0;
    endcase
  end

  assign pend      = pend_q;
  assign data_word = data_q;
endmodule

// File: rtl/prb_access_bridge.sv
`timescale 1ns/1ps
module prb_access_bridge
  import prb_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 32,
  parameter int WIN_BITS = 8,
  parameter logic [WIN_BITS-1:0] WIN_TAG = '1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          core_req_valid,
  output logic          core_req_ready,
  input  logic          core_req_debug,
  input  logic          core_req_fetch,
  input  logic          core_req_write,
  input  logic [1:0]    core_req_size,
  input  logic [AW-1:0] core_req_addr,
  input  logic [DW-1:0] core_req_wdata,
  output logic [DW-1:0] core_rsp_rdata,
  output logic          core_rsp_err,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic          mem_req_write,
  output logic [1:0]    mem_req_size,
  output logic [AW-1:0] mem_req_addr,
  output logic [DW-1:0] mem_req_wdata,
  input  logic [DW-1:0] mem_rsp_rdata,
  input  logic [1:0]    tp_sel,
  input  logic          tp_wr,
  input  logic [DW-1:0] tp_wdata,
  output logic [DW-1:0] tp_rdata
);
  localparam int LB = $clog2(DW / 8);

  bst_e           st_q, st_d;
  logic           hit;
  logic [AW-1:0]  phys;
  logic           idle;
  logic           post;
  logic           bad;
  logic           done;
  logic           pend;
  acc_attr_t      attr;
  logic [LB-1:0]  lane_q;
  logic [SZW-1:0] size_q;
  logic           rd_q;
  logic [LB-1:0]  lane_sel;
  logic [SZW-1:0] size_sel;
  logic [DW-1:0]  wdata_rj;
  logic [DW-1:0]  rdata_lane;
  logic [DW-1:0]  data_word;

  prb_win_decode #(.AW(AW), .WIN_BITS(WIN_BITS), .WIN_TAG(WIN_TAG)) u_dec (
    .addr (core_req_addr),
    .hit  (hit),
    .phys (phys)
  );

  assign idle       = (st_q == ST_IDLE);
  assign post       = idle && core_req_valid && hit && core_req_debug;
  assign bad        = idle && core_req_valid && hit && !core_req_debug;
  assign attr.wr    = core_req_write && !core_req_fetch;
  assign attr.fetch = core_req_fetch;
  assign attr.size  = core_req_size;

  assign lane_sel = idle ? core_req_addr[LB-1:0] : lane_q;
  assign size_sel = idle ? core_req_size : size_q;

  prb_lane_align #(.DW(DW)) u_align (
    .lane_off    (lane_sel),
    .size        (size_sel),
    .core_wdata  (core_req_wdata),
    .probe_rdata (data_word),
    .wdata_rj    (wdata_rj),
    .rdata_lane  (rdata_lane)
  );

  prb_probe_regs #(.DW(DW), .AW(AW)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .post      (post),
    .post_phys (phys),
    .post_attr (attr),
    .post_data (wdata_rj),
    .tp_sel    (tp_sel),
    .tp_wr     (tp_wr),
    .tp_wdata  (tp_wdata),
    .tp_rdata  (tp_rdata),
    .pend      (pend),
    .done      (done),
    .data_word (data_word)
  );

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE: if (post) st_d = ST_WAIT;
      ST_WAIT: if (done) st_d = ST_DONE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      lane_q <= '0;
      size_q <= '0;
      rd_q   <= 1'b0;
    end else begin
      st_q <= st_d;
      if (post) begin
        lane_q <= core_req_addr[LB-1:0];
        size_q <= core_req_size;
        rd_q   <= !attr.wr;
      end
    end
  end

  // system memory pass-through
  assign mem_req_valid = idle && core_req_valid && !hit;
  assign mem_req_write = core_req_write && !core_req_fetch;
  assign mem_req_size  = core_req_size;
  assign mem_req_addr  = core_req_addr;
  assign mem_req_wdata = core_req_wdata;

  // completion and response
  assign core_req_ready = (st_q == ST_DONE) || bad || (mem_req_valid && mem_req_ready);
  assign core_rsp_err   = bad;
  assign core_rsp_rdata = (st_q == ST_DONE) ? (rd_q ? rdata_lane : '0) : mem_rsp_rdata;
endmodule

// File: rtl/prb_access_bridge_chk.sv
`timescale 1ns/1ps
module prb_access_bridge_chk #(
  parameter int AW = 32,
  parameter int WIN_BITS = 8,
  parameter logic [WIN_BITS-1:0] WIN_TAG = '1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          core_req_valid,
  input logic          core_req_debug,
  input logic [AW-1:0] core_req_addr,
  input logic          core_req_ready,
  input logic          core_rsp_err,
  input logic          mem_req_valid,
  input logic [1:0]    tp_sel,
  input logic          tp_wr,
  input logic          tp_wd0,
  input logic          pend
);
  logic win_hit;
  assign win_hit = (core_req_addr[AW-1 -: WIN_BITS] == WIN_TAG);

  // R1
  mem_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !win_hit);

  // R2
  post_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend) |-> $past(core_req_valid && core_req_debug && win_hit));

  // R7
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && tp_wr && tp_sel == 2'd0 && !tp_wd0) |=> (core_req_ready && !pend));

  // R8
  stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend |-> !core_req_ready);

  // R10
  err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    core_rsp_err |-> (core_req_ready && !mem_req_valid && !pend));

  // R10
  err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    core_rsp_err |-> (core_req_valid && !core_req_debug && win_hit));

  // R10
  err_nopost_chk: assert property (@(posedge clk) disable iff (!rst_n)
    core_rsp_err |=> !pend);
endmodule

bind prb_access_bridge prb_access_bridge_chk #(
  .AW(AW), .WIN_BITS(WIN_BITS), .WIN_TAG(WIN_TAG)
) chk_i (
  .clk            (clk),
  .rst_n          (rst_n),
  .core_req_valid (core_req_valid),
  .core_req_debug (core_req_debug),
  .core_req_addr  (core_req_addr),
  .core_req_ready (core_req_ready),
  .core_rsp_err   (core_rsp_err),
  .mem_req_valid  (mem_req_valid),
  .tp_sel         (tp_sel),
  .tp_wr          (tp_wr),
  .tp_wd0         (tp_wdata[0]),
  .pend           (pend)
);

// File: tb/prb_access_bridge_tb_top.sv
`timescale 1ns/1ps
module prb_access_bridge_tb_top;
  localparam int DW = 32;
  localparam int AW = 16;
  localparam int WB = 4;
  localparam logic [WB-1:0] TAG = 4'hF;
  localparam logic [31:0] MEMDAT = 32'hA5A5_5A5A;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          core_req_valid = 1'b0;
  logic          core_req_ready;
  logic          core_req_debug = 1'b0;
  logic          core_req_fetch = 1'b0;
  logic          core_req_write = 1'b0;
  logic [1:0]    core_req_size = 2'd0;
  logic [AW-1:0] core_req_addr = '0;
  logic [DW-1:0] core_req_wdata = '0;
  logic [DW-1:0] core_rsp_rdata;
  logic          core_rsp_err;
  logic          mem_req_valid;
  logic          mem_req_ready = 1'b1;
  logic          mem_req_write;
  logic [1:0]    mem_req_size;
  logic [AW-1:0] mem_req_addr;
  logic [DW-1:0] mem_req_wdata;
  logic [DW-1:0] mem_rsp_rdata = MEMDAT;
  logic [1:0]    tp_sel = 2'd0;
  logic          tp_wr = 1'b0;
  logic [DW-1:0] tp_wdata = '0;
  logic [DW-1:0] tp_rdata;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  prb_access_bridge #(.DW(DW), .AW(AW), .WIN_BITS(WB), .WIN_TAG(TAG)) dut_i (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] s, output logic [31:0] v);
    tp_sel = s;
    #0.2;
    v = tp_rdata;
  endtask

  function automatic logic [31:0] szmask(input int sz);
    return (sz >= 2) ? 32'hFFFF_FFFF : ((32'd1 << (8 * (1 << sz))) - 32'd1);
  endfunction

  // kind: 0 load, 1 store, 2 fetch (driven with write high)
  task automatic probe_access(input int kind, input int sz, input int off,
                              input logic [11:0] base, input int hold);
    logic [15:0] a;
    logic [31:0] wd, pd, v, ectl;
    a  = {TAG, base[11:2], 2'(off)};
    wd = 32'h8765_4321 ^ {a, a};
    pd = 32'hC3D2_E1F0 ^ {16'h0, a};
    ectl = 32'd1 | (32'(kind == 1) << 1) | (32'(kind == 2) << 2) | (32'(sz) << 3);
    @(negedge clk);
    core_req_valid = 1'b1; core_req_debug = 1'b1;
    core_req_write = (kind != 0); core_req_fetch = (kind == 2);
    core_req_size = 2'(sz); core_req_addr = a; core_req_wdata = wd;
    #1;
    check("R1 window no mem", 32'(mem_req_valid), 32'd0);
    check("R8 not ready at post", 32'(core_req_ready), 32'd0);
    @(negedge clk); #1;
    rd(2'd0, v);
    check("R2 pending set", 32'(v[0]), 32'd1);
    check(kind == 2 ? "R9 fetch ctrl" : "R4 ctrl fields", v, ectl);
    rd(2'd1, v);
    check("R3 address word", v, {16'h0, 4'h0, a[11:0]});
    rd(2'd2, v);
    if (kind == 1) check("R5 store data", v, (wd >> (8 * off)) & szmask(sz));
    else           check("R6 load data cleared", v, 32'd0);
    rd(2'd3, v);
    check("R12 unused select", v, 32'd0);
    // writes that must be ignored while pending
    tp_wr = 1'b1; tp_sel = 2'd1; tp_wdata = 32'hFFFF_FFFF;
    @(negedge clk);
    tp_sel = 2'd0; tp_wdata = 32'hFFFF_FFFF;
    @(negedge clk);
    tp_wr = 1'b0; #1;
    rd(2'd1, v);
    check("R8 address write ignored", v, {16'h0, 4'h0, a[11:0]});
    rd(2'd0, v);
    check("R8 pend kept", v, ectl);
    check("R8 stalled", 32'(core_req_ready), 32'd0);
    for (int i = 0; i < hold; i++) begin
      @(negedge clk); #1;
      check("R8 stall hold", 32'(core_req_ready), 32'd0);
    end
    if (kind != 1) begin
      tp_wr = 1'b1; tp_sel = 2'd2; tp_wdata = pd;
      @(negedge clk);
    end
    tp_wr = 1'b1; tp_sel = 2'd0; tp_wdata = 32'hFFFF_FFFE;
    @(negedge clk);
    tp_wr = 1'b0; #1;
    check("R7 ready after release", 32'(core_req_ready), 32'd1);
    rd(2'd0, v);
    check("R7 pend cleared", 32'(v[0]), 32'd0);
    if (kind == 1) check("R6 store returns zero", core_rsp_rdata, 32'd0);
    else           check(kind == 2 ? "R9 fetch data" : "R6 load data",
                         core_rsp_rdata, (pd & szmask(sz)) << (8 * off));
    core_req_valid = 1'b0;
    @(negedge clk); #1;
    check("R7 ready one cycle", 32'(core_req_ready), 32'd0);
  endtask

  task automatic pass_through(input logic [15:0] a, input logic dbg, input logic wr);
    @(negedge clk);
    core_req_valid = 1'b1; core_req_debug = dbg; core_req_write = wr;
    core_req_fetch = 1'b0; core_req_size = 2'd2; core_req_addr = a;
    core_req_wdata = 32'h0BAD_F00D;
    #1;
    check("R1 mem valid", 32'(mem_req_valid), 32'd1);
    check("R1 mem addr", 32'(mem_req_addr), 32'(a));
    check("R1 mem write", 32'(mem_req_write), 32'(wr));
    check("R1 mem ready", 32'(core_req_ready), 32'd1);
    check("R1 mem data", core_rsp_rdata, MEMDAT);
    check("R1 no err", 32'(core_rsp_err), 32'd0);
    core_req_valid = 1'b0;
  endtask

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    #1;
    rd(2'd0, v); check("R11 ctrl reset", v, 32'd0);
    rd(2'd1, v); check("R11 addr reset", v, 32'd0);
    rd(2'd2, v); check("R11 data reset", v, 32'd0);
    check("R11 ready reset", 32'(core_req_ready), 32'd0);
    @(negedge clk);
    rst_n = 1'b1;

    // R7: release write with nothing pending has no effect
    @(negedge clk);
    tp_wr = 1'b1; tp_sel = 2'd0; tp_wdata = 32'd0;
    @(negedge clk);
    tp_wr = 1'b0; #1;
    check("R7 idle release ignored", 32'(core_req_ready), 32'd0);
    rd(2'd0, v); check("R7 idle ctrl", v, 32'd0);

    pass_through(16'hEFFC, 1'b1, 1'b0);
    pass_through(16'h0000, 1'b0, 1'b1);
    pass_through(16'h7FF0, 1'b1, 1'b1);

    // R10: window access outside debug mode
    @(negedge clk);
    core_req_valid = 1'b1; core_req_debug = 1'b0; core_req_write = 1'b0;
    core_req_fetch = 1'b0; core_req_size = 2'd2; core_req_addr = 16'hF010;
    #1;
    check("R10 err", 32'(core_rsp_err), 32'd1);
    check("R10 ready", 32'(core_req_ready), 32'd1);
    check("R10 no mem", 32'(mem_req_valid), 32'd0);
    core_req_valid = 1'b0;
    @(negedge clk); #1;
    rd(2'd0, v); check("R10 nothing posted", 32'(v[0]), 32'd0);
    check("R10 err ends", 32'(core_rsp_err), 32'd0);

    // sweep of kinds, sizes and lane offsets
    for (int k = 0; k < 3; k++)
      for (int s = 0; s < 3; s++)
        for (int o = 0; o < 4; o += (1 << s))
          probe_access(k, s, o, 12'(k * 1024 + s * 256 + o * 20), (k + s + o) % 4);

    // window edge at its lowest address
    probe_access(0, 2, 0, 12'h000, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule